// File: doc/BRIEF.md
# Line Frame Formatter with Differential Biphase Encoder

This block turns per-frame payload bytes into the serial symbol stream for a two-wire digital subscriber line. In framed mode it builds each line frame from an alternating synchronisation bit, an optional housekeeping bit, the signalling (D) bits and one or two bearer (B) bytes. The layout depends on the selected line rate and on whether the whole D byte is carried in the first bearer slot. In modem mode it forwards a continuous serial stream and adds no overhead.

Every NRZ bit is first differentially encoded: it is XORed with the previous encoded bit, so the line polarity carries no meaning. Each encoded bit is then sent as a biphase cell of two half-symbols, which always changes level at mid-cell. The block advances one half-symbol per pulse of a twice-baud enable. It takes one new NRZ bit every second enable and flags that moment to the data source.

Top module: `line_frame_encoder`

## Requirements
- R1: With `rate_hi`=0 a frame is 10 cells long. Position 0 carries the sync bit, position 1 carries `d_byte[0]`, and positions 2 to 9 carry `b1_byte[0]` to `b1_byte[7]` in that order.
- R2: With `rate_hi`=1 a frame is 20 cells long, in this order: sync, `hk_bit`, `d_byte[1]`, `d_byte[0]`, `b1_byte[0]` to `b1_byte[7]`, then `b2_byte[0]` to `b2_byte[7]`. At the low rate `hk_bit` and `b2_byte` have no effect.
- R3: The sync bit is 1 in the first frame after reset and alternates 0, 1, 0, ... in each later frame.
- R4: With `d_in_b`=1, `d_byte[0]` to `d_byte[7]` take the place of the B1 byte in the B1 slot, and the D bit positions of R1 and R2 carry a constant 1.
- R5: The encoded bit of each cell is the NRZ bit XORed with the encoded bit of the previous cell. The encoder state is 0 after reset.
- R6: Each cell puts out the inverse of its encoded bit in the first half and the encoded bit in the second half. A rising mid-cell transition therefore stands for encoded 1 and a falling one for encoded 0.
- R7: With `modem_en`=1 each cell carries `mdm_bit`, as sampled when `bit_req` is high, with no sync, housekeeping or D insertion. `frm_start` stays 0.
- R8: `line_sym` changes only in the cycle after a `sym_en` pulse. `bit_req` is high exactly during a `sym_en` pulse that starts a cell, which is every second pulse.
- R9: `frm_start` marks the cell start at frame position 0. The bytes, `hk_bit`, `rate_hi` and `d_in_b` are sampled there, and changes to them later in the frame have no effect.
- R10: After reset `line_sym` is 0, and the first cell begins a frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_en | input | 1 | Half-symbol advance enable (twice the baud rate) |
| rate_hi | input | 1 | 0: 10-cell frame, 1: 20-cell frame |
| d_in_b | input | 1 | Carry the full D byte in the B1 slot |
| modem_en | input | 1 | Transparent stream mode |
| hk_bit | input | 1 | Housekeeping bit for the high-rate frame |
| d_byte | input | 8 | Signalling byte |
| b1_byte | input | 8 | First bearer byte |
| b2_byte | input | 8 | Second bearer byte |
| mdm_bit | input | 1 | Serial data in modem mode |
| bit_req | output | 1 | High while the current enable consumes a new bit |
| frm_start | output | 1 | High while the current enable starts a frame |
| line_sym | output | 1 | Two-level line symbol |

## Verification
`bit_req` and `frm_start` are combinational from `sym_en`, so the bench checks them right after it raises the enable and before the clock edge. The first-half symbol of a cell is registered on the edge that samples the enable, and the bench reads it on the following falling edge. The second half appears the same way, one enable later. The bench inserts varying idle gaps between enables and checks that the symbol holds through them. It then decodes each pair of halves back to NRZ against a frame image it builds from the bytes it applied. It changes the inputs right after the frame-start cell to show that the sampled values stay in force.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;

  // value sent in D positions that are not carrying D data
  localparam logic IDLE_FILL = 1'b1;
endpackage

// File: rtl/lfe_frame_seq.sv
module lfe_frame_seq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_adv,
  input  logic              rate_hi,
  input  logic              d_in_b,
  input  logic              modem_en,
  input  logic              hk_bit,
  input  logic [BYTE_W-1:0] d_byte,
  input  logic [BYTE_W-1:0] b1_byte,
  input  logic [BYTE_W-1:0] b2_byte,
  input  logic              mdm_bit,
  output logic              nrz_bit,
  output logic              frm_start
);
  import lfe_pkg::*;

  localparam int LO_BITS = 2 + BYTE_W;
  localparam int HI_BITS = 4 + 2 * BYTE_W;
  localparam int POS_W   = $clog2(HI_BITS);
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam logic [POS_W-1:0] LO_LAST = POS_W'(LO_BITS - 1);
  localparam logic [POS_W-1:0] HI_LAST = POS_W'(HI_BITS - 1);
  localparam logic [POS_W-1:0] LO_B1   = POS_W'(2);
  localparam logic [POS_W-1:0] HI_B1   = POS_W'(4);
  localparam logic [POS_W-1:0] HI_B2   = POS_W'(4 + BYTE_W);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic              sync_q, sync_d;
  logic              rate_q, dinb_q, hk_q;
  logic [BYTE_W-1:0] d_q, b1_q, b2_q;
  logic              at_start, last_pos, frame_bit;
  logic [POS_W-1:0]  rel;
  logic [BYTE_W-1:0] slot1;

  assign at_start  = (pos_q == '0);
  assign last_pos  = (pos_q == (rate_q ? HI_LAST : LO_LAST));
  assign frm_start = cell_adv & ~modem_en & at_start;
  assign slot1     = dinb_q ? d_q : b1_q;

  always_comb begin
    pos_d  = pos_q;
    sync_d = sync_q;
    if (modem_en) begin
      pos_d = '0;
    end else if (cell_adv) begin
      pos_d = last_pos ? '0 : pos_q + 1'b1;
      if (at_start) sync_d = ~sync_q;
    end
  end

  always_comb begin
    frame_bit = IDLE_FILL;
    rel       = '0;
    if (at_start) begin
      frame_bit = sync_q;
    end else if (!rate_q) begin
      if (pos_q == POS_W'(1)) begin
        frame_bit = dinb_q ? IDLE_FILL : d_q[0];
      end else begin
        rel       = pos_q - LO_B1;
        frame_bit = slot1[rel[IDX_W-1:0]];
      end
    end else begin
      if (pos_q == POS_W'(1)) begin
        frame_bit = hk_q;
      end else if (pos_q == POS_W'(2)) begin
        frame_bit = dinb_q ? IDLE_FILL : d_q[1];
      end else if (pos_q == POS_W'(3)) begin
        frame_bit = dinb_q ? IDLE_FILL : d_q[0];
      end else if (pos_q < HI_B2) begin
        rel       = pos_q - HI_B1;
        frame_bit = slot1[rel[IDX_W-1:0]];
      end else begin
        rel       = pos_q - HI_B2;
        frame_bit = b2_q[rel[IDX_W-1:0]];
      end
    end
  end

  assign nrz_bit = modem_en ? mdm_bit : frame_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sync_q <= 1'b1;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 1'b0;
      dinb_q <= 1'b0;
      hk_q   <= 1'b0;
      d_q    <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
    end else if (frm_start) begin
      rate_q <= rate_hi;
      dinb_q <= d_in_b;
      hk_q   <= hk_bit;
      d_q    <= d_byte;
      b1_q   <= b1_byte;
      b2_q   <= b2_byte;
    end
  end

  AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= HI_LAST); // R2
  AST_SYNC_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (sync_q != $past(sync_q))); // R3
  AST_MODEM_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    modem_en |-> !frm_start); // R7
  AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_q && pos_q == LO_LAST && cell_adv && !modem_en) |=> (pos_q == '0)); // R1
endmodule

// File: rtl/lfe_diff_enc.sv
module lfe_diff_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_adv,
  input  logic nrz_bit,
  output logic enc_cur,
  output logic enc_prev
);
  logic enc_q, enc_d;

  always_comb begin
    enc_d = enc_q;
    if (cell_adv) enc_d = nrz_bit ^ enc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enc_q <= 1'b0;
    else        enc_q <= enc_d;
  end

  assign enc_cur  = nrz_bit ^ enc_q;
  assign enc_prev = enc_q;

  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_adv |=> $stable(enc_q)); // R5
  AST_ENC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_adv && nrz_bit) |=> (enc_q != $past(enc_q))); // R5
endmodule

// File: rtl/lfe_biphase.sv
module lfe_biphase (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_en,
  input  logic enc_cur,
  input  logic enc_prev,
  output logic cell_adv,
  output logic line_sym
);
  import lfe_pkg::*;

  half_e half_q, half_d;
  logic  sym_q, sym_d;

  assign cell_adv = sym_en & (half_q == HALF_FIRST);

  always_comb begin
    half_d = half_q;
    sym_d  = sym_q;
    if (sym_en) begin
      if (half_q == HALF_FIRST) begin
        sym_d  = ~enc_cur;
        half_d = HALF_SECOND;
      end else begin
        sym_d  = enc_prev;
        half_d = HALF_FIRST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_FIRST;
      sym_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      sym_q  <= sym_d;
    end
  end

  assign line_sym = sym_q;

  AST_MID_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && half_q == HALF_SECOND) |=> (sym_q != $past(sym_q))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> $stable(sym_q)); // R8
endmodule

// File: rtl/line_frame_encoder.sv
module line_frame_encoder #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_en,
  input  logic              rate_hi,
  input  logic              d_in_b,
  input  logic              modem_en,
  input  logic              hk_bit,
  input  logic [BYTE_W-1:0] d_byte,
  input  logic [BYTE_W-1:0] b1_byte,
  input  logic [BYTE_W-1:0] b2_byte,
  input  logic              mdm_bit,
  output logic              bit_req,
  output logic              frm_start,
  output logic              line_sym
);
  logic cell_adv, nrz_bit, enc_cur, enc_prev;

  lfe_frame_seq #(.BYTE_W(BYTE_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .cell_adv(cell_adv),
    .rate_hi(rate_hi), .d_in_b(d_in_b), .modem_en(modem_en),
    .hk_bit(hk_bit), .d_byte(d_byte), .b1_byte(b1_byte),
    .b2_byte(b2_byte), .mdm_bit(mdm_bit),
    .nrz_bit(nrz_bit), .frm_start(frm_start)
  );

  lfe_diff_enc i_diff (
    .clk(clk), .rst_n(rst_n), .cell_adv(cell_adv), .nrz_bit(nrz_bit),
    .enc_cur(enc_cur), .enc_prev(enc_prev)
  );

  lfe_biphase i_bph (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en),
    .enc_cur(enc_cur), .enc_prev(enc_prev),
    .cell_adv(cell_adv), .line_sym(line_sym)
  );

  assign bit_req = cell_adv;

  AST_REQ_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |-> sym_en); // R8
  AST_REQ_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req); // R8
  AST_START_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> bit_req); // R9
endmodule

// File: tb/test_line_frame_encoder.sv
module test_line_frame_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_en = 1'b0, rate_hi = 1'b0, d_in_b = 1'b0, modem_en = 1'b0;
  logic       hk_bit = 1'b0, mdm_bit = 1'b0;
  logic [7:0] d_byte = '0, b1_byte = '0, b2_byte = '0;
  logic       bit_req, frm_start, line_sym;

  int   n_run = 0, n_fail = 0;
  logic prev_enc = 1'b0;
  logic exp_sync = 1'b1;

  always #4 clk = ~clk;

  line_frame_encoder i_line_frame_encoder (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .rate_hi(rate_hi),
    .d_in_b(d_in_b), .modem_en(modem_en), .hk_bit(hk_bit),
    .d_byte(d_byte), .b1_byte(b1_byte), .b2_byte(b2_byte),
    .mdm_bit(mdm_bit), .bit_req(bit_req), .frm_start(frm_start),
    .line_sym(line_sym)
  );

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic hi, input logic dib, input int p,
      input logic sy, input logic hk, input logic [7:0] d, input logic [7:0] b1,
      input logic [7:0] b2);
    logic [7:0] s1;
    s1 = dib ? d : b1;
    if (p == 0) return sy;
    if (!hi) begin
      if (p == 1) return dib ? 1'b1 : d[0];
      return s1[p-2];
    end
    if (p == 1) return hk;
    if (p == 2) return dib ? 1'b1 : d[1];
    if (p == 3) return dib ? 1'b1 : d[0];
    if (p < 12) return s1[p-4];
    return b2[p-12];
  endfunction

  // one cell: enable, optional idle gap, enable; decode and compare
  task automatic send_cell(input logic exp_nrz, input logic exp_fs, input int gap,
                           input string rq);
    logic h0, h1, enc;
    @(negedge clk); sym_en = 1'b1; #1;
    chk(bit_req === 1'b1, "R8 bit_req at cell start", int'(bit_req), 1);
    chk(frm_start === exp_fs, "R9 frm_start", int'(frm_start), int'(exp_fs));
    @(negedge clk); sym_en = 1'b0; h0 = line_sym;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(line_sym === h0 && bit_req === 1'b0, "R8 hold while idle",
          int'(line_sym), int'(h0));
    end
    @(negedge clk); sym_en = 1'b1; #1;
    chk(bit_req === 1'b0, "R8 no request at second half", int'(bit_req), 0);
    @(negedge clk); sym_en = 1'b0; h1 = line_sym;
    chk(h0 === ~h1, "R6 mid-cell transition", int'(h0), int'(~h1));
    enc = h1;
    chk((enc ^ prev_enc) === exp_nrz, {rq, " R5 decoded bit"},
        int'(enc ^ prev_enc), int'(exp_nrz));
    prev_enc = enc;
  endtask

  task automatic send_frame(input logic hi, input logic dib, input logic hk,
      input logic [7:0] d, input logic [7:0] b1, input logic [7:0] b2, input int gap);
    int n;
    string rq;
    n  = hi ? 20 : 10;
    rq = dib ? "R4" : (hi ? "R2" : "R1");
    rate_hi = hi; d_in_b = dib; hk_bit = hk; d_byte = d; b1_byte = b1; b2_byte = b2;
    for (int p = 0; p < n; p++) begin
      send_cell(frame_bit(hi, dib, p, exp_sync, hk, d, b1, b2), p == 0, gap,
                p == 0 ? "R3 sync" : rq);
      if (p == 0) begin
        // R9: later changes must not disturb the frame under way
        rate_hi = ~hi; d_in_b = ~dib; hk_bit = ~hk;
        d_byte = ~d; b1_byte = ~b1; b2_byte = ~b2;
      end
    end
    rate_hi = hi;
    exp_sync = ~exp_sync;
  endtask

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    chk(line_sym === 1'b0, "R10 reset line_sym", int'(line_sym), 0);
    chk(bit_req === 1'b0 && frm_start === 1'b0, "R10 reset strobes",
        int'(bit_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_sym === 1'b0, "R10 idle after reset", int'(line_sym), 0);

    // first frame checks R10 start, R3 sync=1 and R5 zero initial state
    send_frame(1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3, 8'h00, 0);

    // sweep rate x d_in_b x byte patterns, two frames each
    for (int r = 0; r < 2; r++)
      for (int db = 0; db < 2; db++)
        for (int pt = 0; pt < 4; pt++)
          for (int f = 0; f < 2; f++)
            send_frame(logic'(r), logic'(db), logic'(pt[0] ^ f[0]),
                       8'(8'h1D * (pt + 1) + f), 8'(8'hA7 ^ (pt * 37)),
                       8'(8'h3C + pt * 53 + f), (pt + f) % 3);

    // R7: transparent stream, frame inputs wiggle and must not matter
    modem_en = 1'b1;
    lf = 8'hB5;
    for (int i = 0; i < 40; i++) begin
      mdm_bit = lf[0];
      d_byte = 8'(i); b1_byte = 8'(i * 3); hk_bit = logic'(i % 2);
      send_cell(lf[0], 1'b0, i % 2, "R7 modem");
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[4], lf[7:1]};
    end
    modem_en = 1'b0;

    // back to frames: restarts at position 0, sync continues alternating
    send_frame(1'b1, 1'b0, 1'b1, 8'hFF, 8'h01, 8'h80, 1);
    send_frame(1'b1, 1'b1, 1'b0, 8'h96, 8'hFF, 8'h0F, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule